// File: doc/BRIEF.md
# Latched-Input Byte-Writable Static Memory

This block is a synthesizable model of an 18-bit-wide static memory whose inputs pass through holding stages before they reach the array. The address and the chip select share one holding stage, and write data has a separate one. Each stage has its own enable. While an enable is high, its stage passes its inputs straight through. While the enable is low, the stage keeps the value it had on the last clock edge at which the enable was high.

The 18-bit word is split into two 9-bit lanes. Each lane has its own active-low write strobe. A bus master can therefore capture the address and data early in a cycle and commit either half, or both halves, later. If both enables are tied high, the block acts as a plain SRAM: writes happen on the clock edge and reads are combinational.

The output is a data word qualified by a valid flag. The valid flag stands in for the pins leaving high impedance. There is no ready input, because a memory read has no back-pressure: a consumer must take `rdata_o` in any cycle where `rvalid_o` is high. Memory contents are not cleared by reset.

Top module: `latched_bw_sram`

## Requirements
- R1: While `addr_le_i` is 1, the address and chip select used for reads and writes are the ones on the pins in the same cycle.
- R2: While `addr_le_i` is 0, the address and chip select used are the values that were on the pins at the last rising clock edge at which `addr_le_i` was 1. This includes the edge at which the enable falls while a write is committed.
- R3: While `data_le_i` is 1, write data comes from `wdata_i` in the same cycle. While `data_le_i` is 0, write data is the value captured at the last edge with `data_le_i` = 1. This stage works independently of `addr_le_i`.
- R4: When `wr_lo_n_i` = 0 at a rising edge with the chip selected, bits 8:0 of the addressed word take the write data bits 8:0. Bits 17:9 are unchanged unless `wr_hi_n_i` is also 0.
- R5: When `wr_hi_n_i` = 0 at a rising edge with the chip selected, bits 17:9 of the addressed word are written. With both strobes low, the whole 18-bit word is written.
- R6: While the effective chip select (active low) is 1, no write happens and `rvalid_o` is 0.
- R7: `rvalid_o` is 1 exactly when the effective chip select is 0, `oe_n_i` is 0 and both strobes are 1. In that case `rdata_o` is the stored word at the effective address.
- R8: Whenever `rvalid_o` is 0, `rdata_o` is all zeros, so no stale data is presented during a write or a deselect.
- R9: After reset, the held chip select is 1 (deselected) and the held address and held data are 0. The array is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and stage captures happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the holding stages |
| addr_le_i | input | 1 | Enable of the address/select stage (1 = pass-through) |
| cs_n_i | input | 1 | Active-low chip select |
| addr_i | input | AW | Word address |
| data_le_i | input | 1 | Enable of the write-data stage (1 = pass-through) |
| wdata_i | input | 18 | Write data |
| wr_lo_n_i | input | 1 | Active-low write strobe for bits 8:0 |
| wr_hi_n_i | input | 1 | Active-low write strobe for bits 17:9 |
| oe_n_i | input | 1 | Active-low output enable |
| rdata_o | output | 18 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid (output driven) |

## Verification
Two events can land on the same rising edge: the address stage closing, and a write being committed. In that case the write must go to the address captured at the earlier edge, not to the address now on the pins. The bench provokes this by lowering `addr_le_i` and a strobe together while it changes `addr_i`. It then judges the result by reading back both the captured address and the address that was on the pins. The same pairing is exercised for the data stage, and a long random phase mixes enables, strobes and selects. In that phase every cycle is compared against a behavioural model that tracks which lanes of each word are known.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  localparam int LANE_W  = 9;
  localparam int N_LANES = 2;
  localparam int WORD_W  = LANE_W * N_LANES;
  typedef logic [N_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/lsram_hold_stage.sv
module lsram_hold_stage #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= RST_VAL;
    else if (en_i) held_q <= d_i;
  end

  // pass-through while enabled, otherwise the captured value
  assign q_o = en_i ? d_i : held_q;
endmodule

// File: rtl/lsram_lane.sv
module lsram_lane #(
  parameter int AW    = 10,
  parameter int W     = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd_o
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[addr_i] <= wd_i;
  end

  assign rd_o = cells[addr_i];
endmodule

// File: rtl/lsram_out_gate.sv
module lsram_out_gate
  import lsram_pkg::*;
(
  input  logic              sel_n_i,
  input  logic              oe_n_i,
  input  lane_mask_t        wr_n_i,
  input  logic [WORD_W-1:0] rd_i,
  output logic [WORD_W-1:0] q_o,
  output logic              valid_o
);
  always_comb begin
    valid_o = !sel_n_i && !oe_n_i && (&wr_n_i);
    q_o     = valid_o ? rd_i : '0;
  end
endmodule

// File: rtl/latched_bw_sram.sv
module latched_bw_sram
  import lsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_le_i,
  input  logic              cs_n_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              data_le_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wr_lo_n_i,
  input  logic              wr_hi_n_i,
  input  logic              oe_n_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int SEL_W = AW + 1;
  localparam logic [SEL_W-1:0] SEL_RST = {1'b1, {AW{1'b0}}};

  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] wd_q;
  logic [WORD_W-1:0] rd_word;
  lane_mask_t        wr_n;
  logic              cs_n_eff;
  logic [AW-1:0]     addr_eff;

  assign wr_n = {wr_hi_n_i, wr_lo_n_i};

  lsram_hold_stage #(.W(SEL_W), .RST_VAL(SEL_RST)) u_sel_stage (
    .clk(clk), .rst_n(rst_n), .en_i(addr_le_i),
    .d_i({cs_n_i, addr_i}), .q_o(sel_q)
  );

  lsram_hold_stage #(.W(WORD_W), .RST_VAL('0)) u_data_stage (
    .clk(clk), .rst_n(rst_n), .en_i(data_le_i),
    .d_i(wdata_i), .q_o(wd_q)
  );

  assign cs_n_eff = sel_q[AW];
  assign addr_eff = sel_q[AW-1:0];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    lsram_lane #(.AW(AW), .W(LANE_W)) u_lane (
      .clk   (clk),
      .we_i  (!cs_n_eff && !wr_n[g]),
      .addr_i(addr_eff),
      .wd_i  (wd_q[g*LANE_W +: LANE_W]),
      .rd_o  (rd_word[g*LANE_W +: LANE_W])
    );
  end

  lsram_out_gate u_gate (
    .sel_n_i(cs_n_eff), .oe_n_i(oe_n_i), .wr_n_i(wr_n),
    .rd_i(rd_word), .q_o(rdata_o), .valid_o(rvalid_o)
  );
endmodule

// File: rtl/latched_bw_sram_chk.sv
module latched_bw_sram_chk #(
  parameter int AW = 10,
  parameter int WW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_le_i,
  input logic          cs_n_i,
  input logic          data_le_i,
  input logic          wr_lo_n_i,
  input logic          wr_hi_n_i,
  input logic          oe_n_i,
  input logic [WW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic [AW:0]   sel_q,
  input logic [WW-1:0] wd_q
);
  // R1
  open_sel_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_le_i && !cs_n_i && !oe_n_i && wr_lo_n_i && wr_hi_n_i) |-> rvalid_o);
  // R2
  closed_sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_le_i && $past(!addr_le_i)) |-> $stable(sel_q));
  // R3
  closed_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_le_i && $past(!data_le_i)) |-> $stable(wd_q));
  // R6
  open_deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_le_i && cs_n_i) |-> !rvalid_o);
  // R7
  strobe_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo_n_i || !wr_hi_n_i || oe_n_i) |-> !rvalid_o);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_o |-> (rdata_o == '0));
endmodule

bind latched_bw_sram latched_bw_sram_chk #(.AW(AW), .WW(18)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_le_i(addr_le_i), .cs_n_i(cs_n_i),
  .data_le_i(data_le_i), .wr_lo_n_i(wr_lo_n_i), .wr_hi_n_i(wr_hi_n_i),
  .oe_n_i(oe_n_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
  .sel_q(sel_q), .wd_q(wd_q)
);

// File: tb/sim_latched_bw_sram.sv
module sim_latched_bw_sram;
  localparam int AW = 10;
  logic clk = 0, rst_n = 0;
  logic ale = 0, cs_n = 1, dle = 0, lo_n = 1, hi_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [17:0] wdata = '0, rdata;
  logic rvalid;
  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R7";

  always #2 clk = ~clk;

  latched_bw_sram #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_le_i(ale), .cs_n_i(cs_n), .addr_i(addr),
    .data_le_i(dle), .wdata_i(wdata), .wr_lo_n_i(lo_n), .wr_hi_n_i(hi_n),
    .oe_n_i(oe_n), .rdata_o(rdata), .rvalid_o(rvalid));

  // behavioural reference: held values plus per-lane known contents
  logic m_cs = 1;
  logic [AW-1:0] m_a = '0;
  logic [17:0] m_d = '0;
  logic [8:0] lo_mem [int];
  logic [8:0] hi_mem [int];

  always @(posedge clk) begin
    logic ec; int ea; logic [17:0] ed;
    if (!rst_n) begin
      m_cs = 1; m_a = '0; m_d = '0;
    end else begin
      ec = ale ? cs_n : m_cs;
      ea = int'(ale ? addr : m_a);
      ed = dle ? wdata : m_d;
      if (!ec && !lo_n) lo_mem[ea] = ed[8:0];
      if (!ec && !hi_n) hi_mem[ea] = ed[17:9];
      if (ale) begin m_cs = cs_n; m_a = addr; end
      if (dle) m_d = wdata;
    end
  end

  task automatic cmp();
    logic ec, ev; int ea;
    ec = ale ? cs_n : m_cs;
    ea = int'(ale ? addr : m_a);
    ev = rst_n && !ec && !oe_n && lo_n && hi_n;
    checks++;
    if (rvalid !== ev) begin
      fails++;
      $display("FAIL %s rvalid act=%b exp=%b", cur_req, rvalid, ev);
    end
    if (ev && lo_mem.exists(ea) && hi_mem.exists(ea)) begin
      checks++;
      if (rdata !== {hi_mem[ea], lo_mem[ea]}) begin
        fails++;
        $display("FAIL %s rdata act=%h exp=%h", cur_req, rdata, {hi_mem[ea], lo_mem[ea]});
      end
    end else if (!ev) begin
      checks++;
      if (rdata !== '0) begin
        fails++;
        $display("FAIL R8 rdata act=%h exp=0", rdata);
      end
    end
  endtask

  task automatic drv(input logic c, input logic al, input int a, input logic dl,
                     input logic [17:0] d, input logic l, input logic h, input logic o);
    @(negedge clk);
    cs_n = c; ale = al; addr = AW'(a); dle = dl; wdata = d;
    lo_n = l; hi_n = h; oe_n = o;
    #1 cmp();
  endtask

  task automatic expect_word(input string tag, input logic v, input logic [17:0] w);
    checks++;
    if (rvalid !== v || (v && rdata !== w)) begin
      fails++;
      $display("FAIL %s act=%b/%h exp=%b/%h", tag, rvalid, rdata, v, w);
    end
  endtask

  function automatic logic [17:0] pat(input int i);
    return 18'(i * 32'h1234 + 5);
  endfunction

  initial begin
    logic [17:0] w2, w3;
    cur_req = "R9";
    for (int i = 0; i < 3; i++) drv(0, 0, 0, 0, 0, 1, 1, 0);
    @(negedge clk); rst_n = 1;
    drv(0, 0, 0, 0, 18'h3FFFF, 0, 0, 0);     // strobes ignored: held select is 1
    expect_word("R9", 0, 0);
    drv(0, 0, 0, 0, 0, 1, 1, 0);
    expect_word("R9", 0, 0);

    cur_req = "R1";
    for (int i = 0; i < 8; i++) drv(0, 1, i, 1, pat(i), 0, 0, 1);
    for (int i = 0; i < 8; i++) begin
      drv(0, 1, i, 1, 0, 1, 1, 0);
      expect_word("R1", 1, pat(i));
    end

    cur_req = "R4";
    drv(0, 1, 2, 1, 18'h3FFFF, 0, 1, 1);
    drv(0, 1, 2, 1, 0, 1, 1, 0);
    w2 = (pat(2) & 18'h3FE00) | 18'h001FF;
    expect_word("R4", 1, w2);

    cur_req = "R5";
    drv(0, 1, 3, 1, 18'h00000, 1, 0, 1);
    drv(0, 1, 3, 1, 0, 1, 1, 0);
    w3 = pat(3) & 18'h001FF;
    expect_word("R5", 1, w3);

    cur_req = "R2";
    drv(0, 1, 4, 1, 0, 1, 1, 0);
    drv(0, 0, 6, 1, 0, 1, 1, 0);
    expect_word("R2", 1, pat(4));
    drv(0, 1, 5, 1, 18'h2AAAA, 1, 1, 1);     // capture address 5
    drv(0, 0, 7, 1, 18'h15555, 0, 0, 1);     // stage closes as the write commits
    drv(0, 1, 5, 1, 0, 1, 1, 0);
    expect_word("R2", 1, 18'h15555);
    drv(0, 1, 7, 1, 0, 1, 1, 0);
    expect_word("R2", 1, pat(7));

    cur_req = "R3";
    drv(0, 1, 1, 1, 18'h0F0F0, 1, 1, 1);
    drv(0, 1, 1, 0, 18'h3C3C3, 0, 0, 1);
    drv(0, 1, 1, 1, 0, 1, 1, 0);
    expect_word("R3", 1, 18'h0F0F0);

    cur_req = "R6";
    drv(1, 1, 0, 1, 18'h11111, 0, 0, 1);
    drv(0, 1, 0, 1, 0, 1, 1, 0);
    expect_word("R6", 1, pat(0));
    drv(1, 1, 0, 1, 0, 1, 1, 0);
    drv(0, 0, 0, 1, 18'h22222, 0, 0, 0);     // held select still 1
    expect_word("R6", 0, 0);
    drv(0, 1, 0, 1, 0, 1, 1, 0);
    expect_word("R6", 1, pat(0));

    cur_req = "R7";
    drv(0, 1, 0, 1, 0, 1, 1, 1);
    expect_word("R7", 0, 0);
    cur_req = "R8";
    drv(0, 1, 0, 1, 18'h3FFFF, 1, 0, 0);
    expect_word("R8", 0, 0);

    cur_req = "R7";
    for (int i = 0; i < 600; i++)
      drv(($urandom % 5) == 0, $urandom % 2, $urandom % 8, $urandom % 2,
          18'($urandom), ($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 4) == 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule